// File: doc/BRIEF.md
# Stereo Soft-Ramp Digital Attenuator

This block is the gain stage of a two-channel audio path. Each channel owns an 8-bit up/down gain counter, and that counter sets the channel gain as a linear fraction of full scale. A count of 255 is unity gain and a count of 0 is silence. Software writes an attenuation target per channel, or sets a per-channel mute request. The counter never jumps to a new value. It moves one step toward its goal on every fourth frame strobe, so a full swing from unity to silence takes 1020 frames.

Samples enter as signed 16-bit words and are scaled once per frame. The stored gain is multiplied into the sample and the product is shifted right arithmetically by eight bits. Unity gain is special-cased so the sample passes through bit-exact. A common-control input makes the right channel follow the left channel's written target. Each channel also has a flag that is high while its counter is zero, which downstream mute detection can use.

Top module: `stereo_soft_atten`

## Requirements
- R1: After reset both gain counters read 255, both zero flags are low, both sample outputs are 0, both written targets are 255, mute is released and the common-control mode is off.
- R2: A gain counter changes only on the frame strobe that completes each group of 4 strobes counted from reset (strobes number 4, 8, 12, ...). At such a strobe it changes by exactly one step, and only toward its current goal.
- R3: While a channel's mute request is high, that channel's goal is 0. From 255 the counter reaches 0 after 255 steps (1020 strobes) and then stays at 0.
- R4: When a mute request is released, the counter climbs one step at a time back to the channel's written target.
- R5: A written target below the current count makes the counter step down, and a target above it makes the counter step up. Either way the counter stops on the target. A write strobe on one channel loads the 8-bit data into that channel's target register.
- R6: With common-control high, the right channel's goal is the left channel's written target. With it low, the right channel uses its own stored target, which is kept unchanged while common-control is high.
- R7: On each frame strobe the output is registered as floor(sample × gain / 256), using the gain held before that strobe's step. At gain 255 the output equals the input sample.
- R8: A channel's zero flag is high exactly when its gain counter is 0.
- R9: Sample outputs and gain counters hold their values in every cycle without a frame strobe, whatever the sample inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| in_l | input | 16 | Left sample, signed two's complement |
| in_r | input | 16 | Right sample, signed two's complement |
| wr_l | input | 1 | Load wr_gain into the left target |
| wr_r | input | 1 | Load wr_gain into the right target |
| wr_gain | input | 8 | Target gain data, 255 = unity |
| common_en | input | 1 | Right channel follows the left target |
| mute_l | input | 1 | Soft-mute request, left |
| mute_r | input | 1 | Soft-mute request, right |
| out_l | output | 16 | Scaled left sample |
| out_r | output | 16 | Scaled right sample |
| gain_l | output | 8 | Left gain counter |
| gain_r | output | 8 | Right gain counter |
| zero_l | output | 1 | Left counter is zero |
| zero_r | output | 1 | Right counter is zero |

## Verification
The assertions check several properties on every cycle:
- Gain counters move only on every fourth strobe and by at most one step.
- Outputs hold between strobes.
- Unity gain passes the sample through unchanged.
- A muted channel that has reached zero stays there.

Other behaviours can only be shown by the bench's scenarios:
- The exact strobe count of a full ramp.
- Stopping precisely on a written target.
- The right channel switching goals when common-control toggles.
- Floor rounding of negative products.

To cover these, the bench runs a strobe-by-strobe reference of the gain walk and the product.

// File: rtl/atten_pkg.sv
package atten_pkg;
   localparam int unsigned DEF_SMP_W  = 16;
   localparam int unsigned DEF_GAIN_W = 8;
   localparam int unsigned DEF_DIV    = 4;
   localparam int unsigned NUM_CH     = 2;

   typedef enum logic [1:0] {
      RAMP_HOLD = 2'b00,
      RAMP_DOWN = 2'b01,
      RAMP_UP   = 2'b10
   } ramp_dir_e;
endpackage

// File: rtl/atten_prescaler.sv
module atten_prescaler #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("atten_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign tick = stb;
   end else begin : g_count
      localparam int unsigned CW   = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] phase_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (stb) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
         end
      end

      assign tick = stb && (phase_q == LAST);
   end
endmodule

// File: rtl/atten_ramp.sv
module atten_ramp
   import atten_pkg::*;
#(
   parameter int unsigned GAIN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [GAIN_W-1:0] goal,
   output logic [GAIN_W-1:0] gain,
   output logic              is_zero
);
   localparam logic [GAIN_W-1:0] FULL = '1;

   logic [GAIN_W-1:0] gain_q;
   ramp_dir_e         dir;

   always_comb begin
      if (goal < gain_q)      dir = RAMP_DOWN;
      else if (goal > gain_q) dir = RAMP_UP;
      else                    dir = RAMP_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_q <= FULL;
      end else if (tick) begin
         case (dir)
            RAMP_DOWN: gain_q <= gain_q - 1'b1;
            RAMP_UP:   gain_q <= gain_q + 1'b1;
            default:   gain_q <= gain_q;
         endcase
      end
   end

   assign gain    = gain_q;
   assign is_zero = (gain_q == '0);
endmodule

// File: rtl/atten_scaler.sv
module atten_scaler #(
   parameter int unsigned SMP_W  = 16,
   parameter int unsigned GAIN_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stb,
   input  logic signed [SMP_W-1:0] smp_in,
   input  logic [GAIN_W-1:0]       gain,
   output logic signed [SMP_W-1:0] smp_out
);
   localparam int unsigned PW = SMP_W + GAIN_W + 1;
   localparam logic [GAIN_W-1:0] FULL = '1;

   logic signed [PW-1:0]    prod;
   logic signed [PW-1:0]    prod_sh;
   logic signed [SMP_W-1:0] scaled;

   always_comb begin
      prod    = PW'(smp_in) * $signed({1'b0, gain});
      prod_sh = prod >>> GAIN_W;
      scaled  = (gain == FULL) ? smp_in : prod_sh[SMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_out <= '0;
      end else if (stb) begin
         smp_out <= scaled;
      end
   end
endmodule

// File: rtl/stereo_soft_atten.sv
module stereo_soft_atten
   import atten_pkg::*;
#(
   parameter int unsigned SMP_W    = DEF_SMP_W,
   parameter int unsigned GAIN_W   = DEF_GAIN_W,
   parameter int unsigned STEP_DIV = DEF_DIV
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_stb,
   input  logic signed [SMP_W-1:0] in_l,
   input  logic signed [SMP_W-1:0] in_r,
   input  logic                    wr_l,
   input  logic                    wr_r,
   input  logic [GAIN_W-1:0]       wr_gain,
   input  logic                    common_en,
   input  logic                    mute_l,
   input  logic                    mute_r,
   output logic signed [SMP_W-1:0] out_l,
   output logic signed [SMP_W-1:0] out_r,
   output logic [GAIN_W-1:0]       gain_l,
   output logic [GAIN_W-1:0]       gain_r,
   output logic                    zero_l,
   output logic                    zero_r
);
   if (SMP_W < 2) begin : g_bad_smp
      $error("stereo_soft_atten: SMP_W too small");
   end
   if (GAIN_W < 1) begin : g_bad_gain
      $error("stereo_soft_atten: GAIN_W too small");
   end

   localparam logic [GAIN_W-1:0] FULL = '1;

   logic [GAIN_W-1:0]       tgt_l_q, tgt_r_q;
   logic [GAIN_W-1:0]       goal   [NUM_CH];
   logic [GAIN_W-1:0]       gain   [NUM_CH];
   logic                    zflag  [NUM_CH];
   logic signed [SMP_W-1:0] smp_i  [NUM_CH];
   logic signed [SMP_W-1:0] smp_o  [NUM_CH];
   logic                    tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_l_q <= FULL;
         tgt_r_q <= FULL;
      end else begin
         if (wr_l) tgt_l_q <= wr_gain;
         if (wr_r) tgt_r_q <= wr_gain;
      end
   end

   always_comb begin
      goal[0]  = mute_l ? '0 : tgt_l_q;
      goal[1]  = mute_r ? '0 : (common_en ? tgt_l_q : tgt_r_q);
      smp_i[0] = in_l;
      smp_i[1] = in_r;
   end

   atten_prescaler #(.DIV(STEP_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (frame_stb),
      .tick  (tick)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      atten_ramp #(.GAIN_W(GAIN_W)) u_ramp (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .goal    (goal[c]),
         .gain    (gain[c]),
         .is_zero (zflag[c])
      );

      atten_scaler #(.SMP_W(SMP_W), .GAIN_W(GAIN_W)) u_scale (
         .clk     (clk),
         .rst_n   (rst_n),
         .stb     (frame_stb),
         .smp_in  (smp_i[c]),
         .gain    (gain[c]),
         .smp_out (smp_o[c])
      );
   end

   assign out_l  = smp_o[0];
   assign out_r  = smp_o[1];
   assign gain_l = gain[0];
   assign gain_r = gain[1];
   assign zero_l = zflag[0];
   assign zero_r = zflag[1];
endmodule

// File: rtl/stereo_soft_atten_chk.sv
module stereo_soft_atten_chk #(
   parameter int unsigned SMP_W    = 16,
   parameter int unsigned GAIN_W   = 8,
   parameter int unsigned STEP_DIV = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    frame_stb,
   input logic signed [SMP_W-1:0] in_l,
   input logic                    mute_l,
   input logic signed [SMP_W-1:0] out_l,
   input logic signed [SMP_W-1:0] out_r,
   input logic [GAIN_W-1:0]       gain_l,
   input logic [GAIN_W-1:0]       gain_r,
   input logic                    zero_l
);
   localparam logic [GAIN_W-1:0] FULL = '1;

   int unsigned seen_q;
   logic        step_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= 0;
      else if (frame_stb) seen_q <= (seen_q == STEP_DIV - 1) ? 0 : seen_q + 1;
   end

   assign step_ok = frame_stb && (seen_q == STEP_DIV - 1);

   // R2
   gain_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_ok |=> ($stable(gain_l) && $stable(gain_r)));

   // R2
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (gain_l == $past(gain_l)) ||
               ({1'b0, gain_l} + 1'b1 == {1'b0, $past(gain_l)}) ||
               ({1'b0, $past(gain_l)} + 1'b1 == {1'b0, gain_l}));

   // R3
   mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_l && zero_l) |=> zero_l);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> ($stable(out_l) && $stable(out_r)));

   // R7
   unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && gain_l == FULL) |=> (out_l == $past(in_l)));
endmodule

bind stereo_soft_atten stereo_soft_atten_chk #(
   .SMP_W(SMP_W), .GAIN_W(GAIN_W), .STEP_DIV(STEP_DIV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_stb (frame_stb),
   .in_l      (in_l),
   .mute_l    (mute_l),
   .out_l     (out_l),
   .out_r     (out_r),
   .gain_l    (gain_l),
   .gain_r    (gain_r),
   .zero_l    (zero_l)
);

// File: tb/tb_stereo_soft_atten.sv
`timescale 1ns/1ps
module tb_stereo_soft_atten;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               frame_stb = 1'b0;
   logic signed [15:0] in_l = '0, in_r = '0;
   logic               wr_l = 1'b0, wr_r = 1'b0;
   logic [7:0]         wr_gain = '0;
   logic               common_en = 1'b0, mute_l = 1'b0, mute_r = 1'b0;
   logic signed [15:0] out_l, out_r;
   logic [7:0]         gain_l, gain_r;
   logic               zero_l, zero_r;

   int n_chk = 0, n_bad = 0;
   int stb_cnt = 0;
   int gm_l = 255, gm_r = 255, tl = 255, tr = 255;

   always #2.5 clk = ~clk;

   stereo_soft_atten dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .in_l(in_l), .in_r(in_r),
      .wr_l(wr_l), .wr_r(wr_r), .wr_gain(wr_gain), .common_en(common_en),
      .mute_l(mute_l), .mute_r(mute_r), .out_l(out_l), .out_r(out_r),
      .gain_l(gain_l), .gain_r(gain_r), .zero_l(zero_l), .zero_r(zero_r)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_scale(input int s, input int g);
      if (g == 255) return s;
      return (s * g) >>> 8;
   endfunction

   function automatic int step_to(input int cur, input int goal);
      if (goal < cur) return cur - 1;
      if (goal > cur) return cur + 1;
      return cur;
   endfunction

   // One frame strobe with a reference model of R2, R6, R7 and R8
   task automatic strobe();
      int eo_l, eo_r, el, er;
      eo_l = exp_scale(int'(in_l), gm_l);
      eo_r = exp_scale(int'(in_r), gm_r);
      el = mute_l ? 0 : tl;
      er = mute_r ? 0 : (common_en ? tl : tr);
      if (stb_cnt % 4 == 3) begin
         gm_l = step_to(gm_l, el);
         gm_r = step_to(gm_r, er);
      end
      stb_cnt++;
      @(negedge clk) frame_stb = 1'b1;
      @(negedge clk) frame_stb = 1'b0;
      check(int'(gain_l) == gm_l, "R2 gain_l", int'(gain_l), gm_l);
      check(int'(gain_r) == gm_r, "R2 gain_r", int'(gain_r), gm_r);
      check(int'(out_l) == eo_l, "R7 out_l", int'(out_l), eo_l);
      check(int'(out_r) == eo_r, "R7 out_r", int'(out_r), eo_r);
      check(zero_l == (gm_l == 0), "R8 zero_l", int'(zero_l), int'(gm_l == 0));
      check(zero_r == (gm_r == 0), "R8 zero_r", int'(zero_r), int'(gm_r == 0));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) strobe();
   endtask

   task automatic write(input bit left, input int v);
      @(negedge clk);
      wr_l = left; wr_r = !left; wr_gain = 8'(v);
      @(negedge clk);
      wr_l = 1'b0; wr_r = 1'b0;
      if (left) tl = v; else tr = v;
   endtask

   task automatic t_reset();
      check(gain_l == 8'd255 && gain_r == 8'd255, "R1 gains", int'(gain_l), 255);
      check(!zero_l && !zero_r, "R1 zero flags", int'(zero_l), 0);
      check(out_l == 0 && out_r == 0, "R1 outputs", int'(out_l), 0);
   endtask

   task automatic t_pass();
      in_l = 16'sd12345; in_r = -16'sd32768;
      strobe();
      check(out_l == 16'sd12345, "R7 unity left", int'(out_l), 12345);
      check(out_r == -16'sd32768, "R7 unity right", int'(out_r), -32768);
   endtask

   task automatic t_mute_ramp();
      int p, n;
      p = stb_cnt % 4;
      mute_l = 1'b1;
      in_l = 16'sd20000;
      n = 0;
      while (gain_l != 8'd0 && n < 1100) begin strobe(); n++; end
      check(n == (4 - p) + 4 * 254, "R3 strobes to silence", n, (4 - p) + 4 * 254);
      check(gain_r == 8'd255, "R3 other channel untouched", int'(gain_r), 255);
      run(9);
      check(gain_l == 8'd0 && zero_l, "R3 stays muted", int'(gain_l), 0);
      check(out_l == 0, "R8 muted output", int'(out_l), 0);
   endtask

   task automatic t_release();
      int p, n;
      p = stb_cnt % 4;
      mute_l = 1'b0;
      n = 0;
      while (gain_l != 8'd255 && n < 1100) begin strobe(); n++; end
      check(n == (4 - p) + 4 * 254, "R4 strobes to unity", n, (4 - p) + 4 * 254);
      check(!zero_l, "R8 flag clears", int'(zero_l), 0);
   endtask

   task automatic t_target();
      write(1'b1, 250);
      run(40);
      check(gain_l == 8'd250, "R5 step down stops", int'(gain_l), 250);
      write(1'b1, 252);
      run(20);
      check(gain_l == 8'd252, "R5 step up stops", int'(gain_l), 252);
   endtask

   task automatic t_scale();
      write(1'b1, 128);
      run(4 * 130);
      in_l = -16'sd1001; in_r = 16'sd7;
      strobe();
      check(out_l == -16'sd501, "R7 negative floor", int'(out_l), -501);
      in_l = -16'sd1;
      strobe();
      check(out_l == -16'sd1, "R7 minus one floor", int'(out_l), -1);
   endtask

   task automatic t_common();
      write(1'b0, 200);
      run(4 * 60);
      check(gain_r == 8'd200, "R6 independent right", int'(gain_r), 200);
      common_en = 1'b1;
      run(4 * 75);
      check(gain_r == 8'd128, "R6 follows left", int'(gain_r), 128);
      common_en = 1'b0;
      run(4 * 75);
      check(gain_r == 8'd200, "R6 own target kept", int'(gain_r), 200);
   endtask

   task automatic t_hold();
      logic signed [15:0] ol, or_;
      logic [7:0] gl;
      ol = out_l; or_ = out_r; gl = gain_l;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         in_l = 16'(i * 977); in_r = 16'(-i * 313);
      end
      check(out_l == ol && out_r == or_, "R9 outputs hold", int'(out_l), int'(ol));
      check(gain_l == gl, "R9 gain holds", int'(gain_l), int'(gl));
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pass();
      t_mute_ramp();
      t_release();
      t_target();
      t_scale();
      t_common();
      t_hold();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule